// File: doc/BRIEF.md
# Four-Phase Interlocked Word Link

This block moves a block of data words from a transmitting side to a receiving side that run on unrelated clocks. The transmitter accepts a start strobe together with a word count and a packed block of words. It then sends the words one at a time over a shared data bus, using two handshake wires: a ready line driven by the transmitter and an accept line driven by the receiver.

Each word takes four handshake edges, in a fixed order. Ready rises with the word on the bus. Accept rises and the receiver latches the word. Ready falls and the bus returns to zero. Accept falls. Every edge is made only after the party making it has seen the other party's previous edge. Each side passes the other side's handshake wire through a two-flop synchronizer before acting on it. Because of this, no timing between edges is assumed and the two clocks may have any ratio. A one-cycle done pulse on the transmit side marks the end of the block.

A user loads the block and pulses start. Words then appear on the receive side as one-cycle valid strobes in index order. The user waits for done before starting the next block.

Top module: `hs_link`

## Requirements
- R1: After reset, bus_ready, bus_accept, tx_busy, tx_done and rx_valid are low, and bus_data is zero.
- R2: While bus_ready is high and the transmitter has not yet seen bus_accept high, bus_ready stays high and bus_data holds the current word unchanged.
- R3: Once the transmitter has seen bus_accept high, it lowers bus_ready and drives bus_data to zero in the same cycle.
- R4: The receiver raises bus_accept only after it has seen bus_ready high. In the cycle it raises bus_accept it latches bus_data into rx_word and pulses rx_valid for exactly one rx_clk cycle.
- R5: The receiver keeps bus_accept high while it still sees bus_ready high, and lowers it after it has seen bus_ready low.
- R6: The transmitter does not raise bus_ready for the next word until it has seen bus_accept low again. The only legal order of line states is (ready,accept) = 00, 10, 11, 01, 00.
- R7: Word i of a block is bits [i*8 +: 8] of tx_block. Words are delivered in index order 0 to tx_len-1, with exactly one rx_valid per word.
- R8: tx_busy is high from the cycle after an accepted start until the block ends. tx_done is a single-cycle pulse in the cycle after the last word's handshake has returned to 00, and tx_busy is low in that cycle.
- R9: A start pulse while tx_busy is high is ignored. A start with tx_len of 0 or greater than 8 is ignored and produces no handshake and no done.
- R10: tx_block is captured when a start is accepted. Later changes to tx_block do not alter the words sent.
- R11: A block completes correctly at any ratio between tx_clk and rx_clk, with one full handshake per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit-side clock |
| tx_rst_n | input | 1 | Transmit-side asynchronous reset, active low |
| tx_start | input | 1 | Start strobe for a new block |
| tx_len | input | 4 | Number of words in the block (1 to 8) |
| tx_block | input | 64 | Packed words; word i at bits [i*8 +: 8] |
| tx_busy | output | 1 | A block is in progress |
| tx_done | output | 1 | One-cycle end-of-block pulse |
| rx_clk | input | 1 | Receive-side clock |
| rx_rst_n | input | 1 | Receive-side asynchronous reset, active low |
| rx_valid | output | 1 | One-cycle strobe: rx_word holds a new word |
| rx_word | output | 8 | Last word latched by the receiver |
| bus_data | output | 8 | Shared data bus, zero when ready is low |
| bus_ready | output | 1 | Transmitter handshake line |
| bus_accept | output | 1 | Receiver handshake line |

## Verification
A transmitter that ends up in the wrong state breaks the fixed order of line states within one transmit cycle of the fault. The result is a skipped or reversed state on bus_ready and bus_accept, for example ready rising while accept is still high. It can also appear as a bus word that changes in the middle of a handshake. A wrong word index or a wrong captured block shows up on the first affected word as a mismatch on rx_word. A wrong count shows up at the end of the block as a missing or extra rx_valid, or as a done pulse that comes early, late or lasts two cycles. The bench sweeps every block length at four clock ratios, so each of these faults is compared against arithmetically generated words within a single block.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_DRIVE   = 2'd1,
        TX_RELEASE = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_WAIT = 1'b0,
        RX_HOLD = 1'b1
    } rx_state_e;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hs_sender.sv
module hs_sender
    import hs_pkg::*;
#(
    parameter int W     = 8,
    parameter int MAXW  = 8,
    parameter int SYNC  = 2,
    localparam int LW   = $clog2(MAXW + 1),
    localparam int BW   = MAXW * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len,
    input  logic [BW-1:0] block,
    input  logic          acc_async,
    output logic          ready,
    output logic [W-1:0]  data,
    output logic          busy,
    output logic          done
);

    typedef struct packed {
        tx_state_e     st;
        logic [BW-1:0] blk;
        logic [LW-1:0] len;
        logic [LW-1:0] idx;
        logic          ready;
        logic [W-1:0]  data;
        logic          done;
    } tx_regs_t;

    tx_regs_t r_q, r_d;
    logic     acc_s;

    hs_sync #(.STAGES(SYNC)) u_acc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (acc_async),
        .q     (acc_s)
    );

    function automatic logic [W-1:0] pick(input logic [BW-1:0] b, input logic [LW-1:0] i);
        return b[int'(i)*W +: W];
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            TX_IDLE: begin
                if (start && (len != '0) && (int'(len) <= MAXW)) begin
                    r_d.blk   = block;
                    r_d.len   = len;
                    r_d.idx   = '0;
                    r_d.ready = 1'b1;
                    r_d.data  = pick(block, '0);
                    r_d.st    = TX_DRIVE;
                end
            end
            TX_DRIVE: begin
                if (acc_s) begin
                    r_d.ready = 1'b0;
                    r_d.data  = '0;
                    r_d.st    = TX_RELEASE;
                end
            end
            TX_RELEASE: begin
                if (!acc_s) begin
                    if (r_q.idx + LW'(1) == r_q.len) begin
                        r_d.done = 1'b1;
                        r_d.st   = TX_IDLE;
                    end else begin
                        r_d.idx   = r_q.idx + LW'(1);
                        r_d.ready = 1'b1;
                        r_d.data  = pick(r_q.blk, r_q.idx + LW'(1));
                        r_d.st    = TX_DRIVE;
                    end
                end
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: TX_IDLE, blk: '0, len: '0, idx: '0, ready: 1'b0, data: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ready = r_q.ready;
    assign data  = r_q.data;
    assign busy  = (r_q.st != TX_IDLE);
    assign done  = r_q.done;

    assert_ready_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !acc_s) |=> (ready && $stable(data)));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && acc_s) |=> (!ready && data == '0));

    assert_no_early_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && acc_s) |=> !ready);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !ready));

endmodule

// File: rtl/hs_receiver.sv
module hs_receiver
    import hs_pkg::*;
#(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ready_async,
    input  logic [W-1:0] data_in,
    output logic         accept,
    output logic [W-1:0] word,
    output logic         valid
);

    typedef struct packed {
        rx_state_e    st;
        logic         acc;
        logic [W-1:0] word;
        logic         valid;
    } rx_regs_t;

    rx_regs_t r_q, r_d;
    logic     rdy_s;

    hs_sync #(.STAGES(SYNC)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ready_async),
        .q     (rdy_s)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        unique case (r_q.st)
            RX_WAIT: begin
                if (rdy_s) begin
                    r_d.word  = data_in;
                    r_d.acc   = 1'b1;
                    r_d.valid = 1'b1;
                    r_d.st    = RX_HOLD;
                end
            end
            RX_HOLD: begin
                if (!rdy_s) begin
                    r_d.acc = 1'b0;
                    r_d.st  = RX_WAIT;
                end
            end
            default: r_d.st = RX_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: RX_WAIT, acc: 1'b0, word: '0, valid: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign accept = r_q.acc;
    assign word   = r_q.word;
    assign valid  = r_q.valid;

    assert_accept_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !rdy_s) |=> (!accept && !valid));

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_accept_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rdy_s) |=> accept);

    assert_accept_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !rdy_s) |=> !accept);

endmodule

// File: rtl/hs_link.sv
module hs_link #(
    parameter int W    = 8,
    parameter int MAXW = 8,
    parameter int SYNC = 2,
    localparam int LW  = $clog2(MAXW + 1),
    localparam int BW  = MAXW * W
) (
    input  logic          tx_clk,
    input  logic          tx_rst_n,
    input  logic          tx_start,
    input  logic [LW-1:0] tx_len,
    input  logic [BW-1:0] tx_block,
    output logic          tx_busy,
    output logic          tx_done,
    input  logic          rx_clk,
    input  logic          rx_rst_n,
    output logic          rx_valid,
    output logic [W-1:0]  rx_word,
    output logic [W-1:0]  bus_data,
    output logic          bus_ready,
    output logic          bus_accept
);

    hs_sender #(.W(W), .MAXW(MAXW), .SYNC(SYNC)) u_tx (
        .clk       (tx_clk),
        .rst_n     (tx_rst_n),
        .start     (tx_start),
        .len       (tx_len),
        .block     (tx_block),
        .acc_async (bus_accept),
        .ready     (bus_ready),
        .data      (bus_data),
        .busy      (tx_busy),
        .done      (tx_done)
    );

    hs_receiver #(.W(W), .SYNC(SYNC)) u_rx (
        .clk         (rx_clk),
        .rst_n       (rx_rst_n),
        .ready_async (bus_ready),
        .data_in     (bus_data),
        .accept      (bus_accept),
        .word        (rx_word),
        .valid       (rx_valid)
    );

endmodule

// File: tb/tb_hs_link.sv
module tb_hs_link;

    localparam int W    = 8;
    localparam int MAXW = 8;
    localparam int LW   = 4;
    localparam int BW   = MAXW * W;

    logic          tx_clk = 1'b0;
    logic          rx_clk = 1'b0;
    logic          tx_rst_n = 1'b0;
    logic          rx_rst_n = 1'b0;
    logic          tx_start = 1'b0;
    logic [LW-1:0] tx_len = '0;
    logic [BW-1:0] tx_block = '0;
    logic          tx_busy, tx_done, rx_valid, bus_ready, bus_accept;
    logic [W-1:0]  rx_word, bus_data;

    int rx_half = 7;

    always #10 tx_clk = ~tx_clk;
    always begin
        #(rx_half) rx_clk = ~rx_clk;
    end

    hs_link #(.W(W), .MAXW(MAXW), .SYNC(2)) dut (
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_start(tx_start), .tx_len(tx_len),
        .tx_block(tx_block), .tx_busy(tx_busy), .tx_done(tx_done),
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
        .bus_data(bus_data), .bus_ready(bus_ready), .bus_accept(bus_accept)
    );

    int n_chk = 0, n_fail = 0;
    int rx_chk = 0, rx_fail = 0;
    int ph_chk = 0, ph_fail = 0;
    bit finished = 0;

    // Receive log, filled at rx_clk falling edges
    logic [W-1:0] rx_log [0:1023];
    int rx_total = 0;
    logic prev_valid = 1'b0;
    always @(negedge rx_clk) begin
        if (rx_rst_n) begin
            if (rx_valid) begin
                rx_chk++;
                if (!bus_accept) begin
                    rx_fail++;
                    $display("FAIL R4: rx_valid with bus_accept=%0b expected 1", bus_accept);
                end
                if (prev_valid) begin
                    rx_fail++;
                    $display("FAIL R4: rx_valid high two cycles, actual 1 expected 0");
                end
                if (rx_total < 1024) rx_log[rx_total] = rx_word;
                rx_total++;
            end
            prev_valid = rx_valid;
        end
    end

    // Handshake order monitor at tx_clk falling edges
    int phase = 0;
    int hs_done = 0;
    logic [W-1:0] held;
    logic [W-1:0] bus_log [0:1023];
    int bus_total = 0;
    always @(negedge tx_clk) begin
        int now;
        if (tx_rst_n && rx_rst_n) begin
            now = {30'd0, bus_ready, bus_accept} == 2 ? 1 :
                  {30'd0, bus_ready, bus_accept} == 3 ? 2 :
                  {30'd0, bus_ready, bus_accept} == 1 ? 3 : 0;
            if (now != phase) begin
                ph_chk++;
                if (now != (phase + 1) % 4) begin
                    ph_fail++;
                    $display("FAIL R6: line state order, actual phase %0d expected %0d", now, (phase + 1) % 4);
                end
                if (now == 1) begin
                    held = bus_data;
                    if (bus_total < 1024) bus_log[bus_total] = bus_data;
                    bus_total++;
                end
                if (now == 2) begin
                    ph_chk++;
                    if (bus_data !== held) begin
                        ph_fail++;
                        $display("FAIL R2: bus word changed, actual %0h expected %0h", bus_data, held);
                    end
                end
                if (now == 3) begin
                    ph_chk++;
                    if (bus_data !== '0) begin
                        ph_fail++;
                        $display("FAIL R3: bus not cleared, actual %0h expected 0", bus_data);
                    end
                end
                if (now == 0) hs_done++;
                phase = now;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        int total, fails;
        total = n_chk + rx_chk + ph_chk;
        fails = n_fail + rx_fail + ph_fail;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    function automatic logic [W-1:0] word_of(input int t, input int i);
        return W'((t * 37 + i * 11 + 5) & 8'hFF);
    endfunction

    task automatic run_xfer(input int t, input int len, input bit disturb);
        logic [BW-1:0] blk;
        int base, hbase, bbase, cyc;
        bit seen;
        blk = '0;
        for (int i = 0; i < MAXW; i++) blk[i*W +: W] = word_of(t, i);
        base = rx_total; hbase = hs_done; bbase = bus_total;
        @(negedge tx_clk);
        tx_block = blk; tx_len = LW'(len); tx_start = 1'b1;
        @(negedge tx_clk);
        tx_start = 1'b0;
        check(tx_busy === 1'b1, "R8 busy after start", int'(tx_busy), 1);
        if (disturb) begin
            tx_block = ~blk; tx_len = LW'(MAXW);
            @(negedge tx_clk);
            tx_start = 1'b1;
            @(negedge tx_clk);
            tx_start = 1'b0;
        end
        seen = 0;
        for (cyc = 0; cyc < 20000; cyc++) begin
            if (tx_done) begin seen = 1; break; end
            @(negedge tx_clk);
        end
        check(seen, "R8 done seen", int'(seen), 1);
        check(tx_busy === 1'b0, "R8 busy low at done", int'(tx_busy), 0);
        @(negedge tx_clk);
        check(tx_done === 1'b0, "R8 done one cycle", int'(tx_done), 0);
        check(rx_total - base == len, "R7 word count", rx_total - base, len);
        check(hs_done - hbase == len, "R11 handshakes per block", hs_done - hbase, len);
        for (int i = 0; i < len; i++) begin
            check(rx_log[base + i] === word_of(t, i),
                  disturb ? "R10 R9 received word" : "R4 R7 received word",
                  int'(rx_log[base + i]), int'(word_of(t, i)));
            check(bus_log[bbase + i] === word_of(t, i), "R2 bus word",
                  int'(bus_log[bbase + i]), int'(word_of(t, i)));
        end
        repeat (3) @(negedge tx_clk);
    endtask

    task automatic run_ignored(input int len);
        int base, bbase;
        bit any_done;
        base = rx_total; bbase = bus_total; any_done = 0;
        @(negedge tx_clk);
        tx_block = {MAXW{8'hA5}}; tx_len = LW'(len); tx_start = 1'b1;
        @(negedge tx_clk);
        tx_start = 1'b0;
        for (int c = 0; c < 200; c++) begin
            if (tx_done || tx_busy || bus_ready) any_done = 1;
            @(negedge tx_clk);
        end
        check(!any_done, "R9 bad length ignored", int'(any_done), 0);
        check(rx_total == base && bus_total == bbase, "R9 no handshake", rx_total - base, 0);
    endtask

    initial begin
        int hp [4];
        hp = '{7, 13, 23, 37};
        #100;
        tx_rst_n = 1'b1; rx_rst_n = 1'b1;
        @(negedge tx_clk);
        check(bus_ready === 1'b0, "R1 ready", int'(bus_ready), 0);
        check(bus_accept === 1'b0, "R1 accept", int'(bus_accept), 0);
        check(tx_busy === 1'b0 && tx_done === 1'b0, "R1 busy/done", int'(tx_busy), 0);
        check(rx_valid === 1'b0, "R1 valid", int'(rx_valid), 0);
        check(bus_data === '0, "R1 data", int'(bus_data), 0);
        for (int r = 0; r < 4; r++) begin
            rx_half = hp[r];
            for (int len = 1; len <= MAXW; len++) begin
                run_xfer(r * 16 + len, len, (len % 3) == 0);
            end
        end
        rx_half = 7;
        run_ignored(0);
        run_ignored(9);
        run_xfer(99, MAXW, 1'b1);
        finished = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge tx_clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R11: watchdog expired, actual hung expected done");
            summary();
        end
    end

endmodule